// File: doc/BRIEF.md
# DRAM Core Model with Destructive Row Buffer

This block models the core of a dynamic memory. It has an array of rows and a single row buffer. Every access to data goes through the buffer. A row must first be brought into the buffer. Column reads and column writes then work on the buffered copy. A write-back command returns the buffer to the array.

Bringing a row into the buffer destroys the array copy of that row. The array row is overwritten with a poison pattern, so its data survives only if the buffer is written back later. Each of the four commands keeps the block busy for its own number of clocks. The latencies are in the proportion 6 : 3 : 1 for open, write-back and column access.

Commands arrive over a valid/ready handshake. A command is taken in the cycle in which `cmd_valid` and `cmd_ready` are both high. The block tracks which row is open and detects commands that break the access protocol. It ignores such a command and raises a sticky error flag.

Top module: `dram_rowbuf_core`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `row_open`, `err_flag` and `rd_valid` are all 0.
- R2: Command code 0 (`cmd_op`) opens row `cmd_row` when no row is open. The whole row is copied into the buffer. `cmd_ready` is low for exactly 6 cycles after the accepting edge. When it rises again, `row_open` is 1 and `open_row` equals the opened row.
- R3: Command code 2 reads word `cmd_col` of the buffer. `cmd_ready` is low for exactly 1 cycle. In the cycle in which `cmd_ready` returns high, `rd_data` holds the word and `rd_valid` is high. `rd_valid` is high for that single cycle only.
- R4: Command code 3 writes `cmd_wdata` into word `cmd_col` of the buffer only. The array is not written. `cmd_ready` is low for exactly 1 cycle, and a later read of that column returns the new value.
- R5: Command code 1 copies the whole buffer into the opened array row. `cmd_ready` is low for exactly 3 cycles, and `row_open` is 0 afterwards. Data written back survives later opens of other rows.
- R6: Opening a row overwrites every word of that array row with 16'hDEAD. If the buffer is then lost without a write-back, a later open of the same row reads 16'hDEAD in every column.
- R7: A read, write or write-back (codes 1, 2 and 3) issued with no row open is illegal. It is accepted without any busy cycle and has no other effect: no `rd_valid` is produced. It sets `err_flag`, which stays 1 until reset.
- R8: An open issued while a row is already open is illegal. It sets `err_flag`, takes no busy cycle, and leaves `open_row` and the buffer contents unchanged.
- R9: Reset clears `err_flag`, the open-row state and any command in flight. The array contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_op | input | 2 | 0 open, 1 write-back, 2 column read, 3 column write |
| cmd_row | input | 4 | Row to open |
| cmd_col | input | 3 | Column for read or write |
| cmd_wdata | input | 16 | Data for a column write |
| rd_valid | output | 1 | One-cycle strobe marking `rd_data` as valid |
| rd_data | output | 16 | Word returned by a column read |
| row_open | output | 1 | A row is held in the buffer |
| open_row | output | 4 | Address of the held row |
| err_flag | output | 1 | Sticky protocol-error flag |

## Verification
The hardest state to reach is an array row that holds only the poison pattern. The protocol forces a write-back before any other row can be opened, so ordinary command sequences always restore the data. The stimulus gets there by opening a row and modifying the buffer, then applying reset so that the buffer is discarded while the array is kept. It then reopens the row and expects 16'hDEAD in every column, while a neighbouring row written back earlier must still hold its data.

// File: rtl/dram_rowbuf_core.sv
module dram_rowbuf_core #(
  parameter int ROWS = 16,
  parameter int COLS = 8,
  parameter int DW = 16,
  parameter int LAT_OPEN = 6,
  parameter int LAT_WB = 3,
  parameter int LAT_COL = 1,
  parameter logic [DW-1:0] POISON = 16'hDEAD
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  output logic cmd_ready,
  input  logic [1:0] cmd_op,
  input  logic [$clog2(ROWS)-1:0] cmd_row,
  input  logic [$clog2(COLS)-1:0] cmd_col,
  input  logic [DW-1:0] cmd_wdata,
  output logic rd_valid,
  output logic [DW-1:0] rd_data,
  output logic row_open,
  output logic [$clog2(ROWS)-1:0] open_row,
  output logic err_flag
);
  localparam int RAW = $clog2(ROWS);
  localparam int CAW = $clog2(COLS);
  localparam int RB = COLS * DW;
  localparam int LMAX0 = (LAT_OPEN > LAT_WB) ? LAT_OPEN : LAT_WB;
  localparam int LMAX = (LMAX0 > LAT_COL) ? LMAX0 : LAT_COL;
  localparam int LW = $clog2(LMAX + 1);
  localparam logic [1:0] OP_OPEN = 2'd0;
  localparam logic [1:0] OP_WB = 2'd1;
  localparam logic [1:0] OP_RD = 2'd2;
  localparam logic [1:0] OP_WR = 2'd3;

  logic [RB-1:0] mem [ROWS];
  logic [RB-1:0] buf_q;
  logic [LW-1:0] busy_q;
  logic [1:0] op_q;
  logic [CAW-1:0] col_q;
  logic [DW-1:0] wdata_q;
  logic [RAW-1:0] row_q;
  logic open_q, err_q, rdv_q;
  logic [DW-1:0] rdd_q;
  logic [LW-1:0] lat_sel;

  wire accept = cmd_valid && cmd_ready;
  wire illegal = (cmd_op == OP_OPEN) ? open_q : !open_q;
  wire start = accept && !illegal;
  wire finish = (busy_q == LW'(1));

  assign cmd_ready = (busy_q == '0);
  assign rd_valid = rdv_q;
  assign rd_data = rdd_q;
  assign row_open = open_q;
  assign open_row = row_q;
  assign err_flag = err_q;

  always_comb begin
    case (cmd_op)
      OP_OPEN: lat_sel = LW'(LAT_OPEN);
      OP_WB:   lat_sel = LW'(LAT_WB);
      default: lat_sel = LW'(LAT_COL);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= '0;
      op_q <= OP_OPEN;
      col_q <= '0;
      wdata_q <= '0;
      row_q <= '0;
      open_q <= 1'b0;
      err_q <= 1'b0;
      rdv_q <= 1'b0;
      rdd_q <= '0;
    end else begin
      rdv_q <= 1'b0;
      if (accept && illegal) err_q <= 1'b1;
      if (start) begin
        busy_q <= lat_sel;
        op_q <= cmd_op;
        col_q <= cmd_col;
        wdata_q <= cmd_wdata;
        if (cmd_op == OP_OPEN) row_q <= cmd_row;
      end else if (busy_q != '0) begin
        busy_q <= busy_q - LW'(1);
      end
      if (finish) begin
        case (op_q)
          OP_OPEN: open_q <= 1'b1;
          OP_WB:   open_q <= 1'b0;
          OP_RD: begin
            rdv_q <= 1'b1;
            rdd_q <= buf_q[col_q*DW +: DW];
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && finish) begin
      case (op_q)
        OP_OPEN: begin
          buf_q <= mem[row_q];
          mem[row_q] <= {COLS{POISON}};
        end
        OP_WB: mem[row_q] <= buf_q;
        OP_WR: buf_q[col_q*DW +: DW] <= wdata_q;
        default: ;
      endcase
    end
  end

  assert_busy_after_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && cmd_op == OP_OPEN) |=> !cmd_ready);
  assert_rd_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  assert_wb_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && op_q == OP_WB) |=> !row_open);
  assert_open_poison_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && op_q == OP_OPEN) |=> (mem[row_q] == {COLS{POISON}}));
  assert_illegal_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && illegal) |=> (cmd_ready && err_flag));
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);
  assert_second_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_op == OP_OPEN && row_open) |=> (open_row == $past(open_row) && row_open));
endmodule

// File: tb/dram_rowbuf_core_test.sv
module dram_rowbuf_core_test;
  localparam int ROWS = 16, COLS = 8;
  localparam logic [15:0] POIS = 16'hDEAD;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, cmd_valid = 1'b0;
  logic cmd_ready, rd_valid, row_open, err_flag;
  logic [1:0] cmd_op = '0;
  logic [3:0] cmd_row = '0, open_row;
  logic [2:0] cmd_col = '0;
  logic [15:0] cmd_wdata = '0, rd_data;

  dram_rowbuf_core uut (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_wdata(cmd_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .row_open(row_open), .open_row(open_row),
    .err_flag(err_flag));

  int n_cmp = 0, n_bad = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];
  string cur_tag = "R3";
  logic [15:0] marr [ROWS][COLS];
  logic [15:0] mbuf [COLS];
  bit mopen = 0;
  int mrow = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) chk(0, "R7", "unexpected rd_valid", 1, 0);
      else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rd_data == e, t, "read data", rd_data, e);
      end
    end
  end

  task automatic cmd(input int op, input int r, input int c, input logic [15:0] wd);
    bit legal;
    int lat, n;
    string t;
    legal = (op == 0) ? !mopen : mopen;
    lat = (op == 0) ? 6 : (op == 1) ? 3 : 1;
    if (!legal) t = (op == 0) ? "R8" : "R7";
    else t = (op == 0) ? "R2" : (op == 1) ? "R5" : (op == 2) ? "R3" : "R4";
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op[1:0]; cmd_row = r[3:0]; cmd_col = c[2:0]; cmd_wdata = wd;
    if (legal) begin
      case (op)
        0: begin
          mbuf = marr[r];
          for (int k = 0; k < COLS; k++) marr[r][k] = POIS;
          mopen = 1; mrow = r;
        end
        1: begin marr[mrow] = mbuf; mopen = 0; end
        2: begin exp_q.push_back(mbuf[c]); tag_q.push_back(cur_tag); end
        default: mbuf[c] = wd;
      endcase
    end
    @(posedge clk);
    #1 cmd_valid = 1'b0;
    n = 0;
    @(negedge clk);
    while (!cmd_ready) begin n++; @(negedge clk); end
    chk(n == (legal ? lat : 0), t, "ready-low cycles", n, legal ? lat : 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    mopen = 0;
    exp_q.delete(); tag_q.delete();
  endtask

  function automatic logic [15:0] pat(input int r, input int c);
    return 16'(r * 256 + c * 16 + 5);
  endfunction

  initial begin
    #3000000;
    chk(0, "R1", "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk(cmd_ready && !row_open && !err_flag && !rd_valid, "R1", "reset outputs",
        {cmd_ready, row_open, err_flag, rd_valid}, 4'b1000);

    for (int r = 0; r < 4; r++) begin
      cmd(0, r, 0, 0);
      chk(row_open && open_row == 4'(r), "R2", "open row state", {row_open, open_row}, {1'b1, 4'(r)});
      for (int c = 0; c < COLS; c++) cmd(3, 0, c, pat(r, c));
      cmd(1, 0, 0, 0);
      chk(!row_open, "R5", "row closed after write-back", row_open, 0);
    end

    cur_tag = "R5";
    cmd(0, 2, 0, 0);
    for (int c = 0; c < COLS; c++) cmd(2, 0, c, 0);
    for (int c = COLS - 1; c >= 0; c--) cmd(2, 0, c, 0);
    cmd(1, 0, 0, 0);
    cmd(0, 0, 0, 0);
    cmd(2, 0, 5, 0);
    cur_tag = "R4";
    cmd(3, 0, 5, 16'h1234);
    cmd(2, 0, 5, 0);
    cmd(3, 0, 5, 16'hBEEF);
    cmd(3, 0, 6, 16'h0F0F);
    cmd(2, 0, 6, 0);
    cmd(2, 0, 5, 0);
    cmd(1, 0, 0, 0);
    cur_tag = "R5";
    cmd(0, 0, 0, 0);
    cmd(2, 0, 5, 0);
    cmd(2, 0, 6, 0);
    cmd(1, 0, 0, 0);

    cmd(2, 0, 3, 0);
    chk(err_flag, "R7", "error on read with no row", err_flag, 1);
    cmd(3, 0, 3, 16'h5555);
    cmd(1, 0, 0, 0);
    chk(err_flag, "R7", "error stays set", err_flag, 1);
    cur_tag = "R7";
    cmd(0, 3, 0, 0);
    cmd(2, 0, 3, 0);
    cmd(1, 0, 0, 0);

    do_reset();
    @(negedge clk);
    chk(!err_flag && !row_open, "R9", "reset clears error", {err_flag, row_open}, 0);
    cur_tag = "R8";
    cmd(0, 1, 0, 0);
    cmd(0, 2, 0, 0);
    chk(err_flag, "R8", "error on second open", err_flag, 1);
    chk(open_row == 4'd1 && row_open, "R8", "open row unchanged", open_row, 1);
    cmd(2, 0, 4, 0);
    cmd(3, 0, 0, 16'h7777);

    do_reset();
    @(negedge clk);
    chk(!err_flag && !row_open && cmd_ready, "R9", "reset state", {err_flag, row_open, cmd_ready}, 1);
    cur_tag = "R6";
    cmd(0, 1, 0, 0);
    for (int c = 0; c < COLS; c++) cmd(2, 0, c, 0);
    cmd(1, 0, 0, 0);
    cur_tag = "R9";
    cmd(0, 2, 0, 0);
    for (int c = 0; c < COLS; c++) cmd(2, 0, c, 0);
    cmd(1, 0, 0, 0);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R3", "reads outstanding", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule